// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Controller

This block is the per-processor heart of a local interrupt controller. It keeps three 256-bit vector arrays: pending requests, vectors in service, and the trigger kind of each request. It raises a level interrupt line to the processor whenever a pending vector outranks the current processor priority. That priority is derived from a programmable task priority and from the class of the highest vector already in service.

The processor side has two operations. An acknowledge handshake returns the vector to run and moves it from pending to in-service. If nothing can be delivered, it returns the spurious vector. An end-of-interrupt write retires the highest in-service vector. For a level-triggered vector, that write also emits a one-cycle broadcast so that upstream sources can re-arm.

Configuration and inspection use a 32-bit register port. The register index is address bits 11:4, and each access must be word aligned. The highest-set-bit searches are registered. The block therefore serves an acknowledge or an end-of-interrupt only once the search results reflect every earlier change.

Top module: `intr_accept_ctrl`

## Requirements
- R1: A set request for vector v sets pending bit v. It sets trigger bit v when the level input is 1 and clears it when the level input is 0. Vector v is visible in word v>>5, bit v&31 of the pending (index 0x20+w) and trigger (index 0x18+w) arrays.
- R2: Processor priority (index 0x0A, read-only) equals the task priority (index 0x08, 8 bits) when task bits 7:4 are at least the class (bits 7:4) of the highest in-service vector. Otherwise it equals that class shifted left by four. An empty in-service array counts as class 0.
- R3: `intr` is high only while the enable bit (bit 8 of index 0x0F) is set and the highest pending vector is deliverable. A vector is deliverable when processor priority is zero or when its class exceeds the processor-priority class. The line is correct four cycles after any change.
- R4: An acknowledge while enabled, with a deliverable vector present, returns the highest pending vector on `ack_vec` with an `ack_done` pulse. That vector moves from the pending array to the in-service array.
- R5: An acknowledge while disabled, with no pending vector, or with the highest pending vector held back, returns bits 7:0 of index 0x0F and leaves all arrays unchanged.
- R6: A write to index 0x0B retires the highest set in-service bit. With the in-service array empty it has no effect.
- R7: When a retired vector has its trigger bit set and the directed bit (bit 12 of index 0x0F) is clear, `eoi_bcast` pulses for exactly one cycle with `eoi_bcast_vec` equal to that vector. Otherwise no pulse occurs.
- R8: Index 0x0F keeps only bits 12, 8 and 7:0 of a write; the other bits read as zero.
- R9: An access to an unlisted index, or with address bits 3:0 nonzero, sets bit 7 of the error register (index 0x28). A read of such an access returns zero. Writing zero to index 0x28 clears it.
- R10: Writes to processor priority and to the three arrays have no effect.
- R11: After reset all arrays, task priority and error status are zero, index 0x0F reads 0xFF, and `intr`, `ack_done` and `eoi_bcast` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_req | input | 1 | Request to post a vector |
| set_vec | input | 8 | Vector to post |
| set_lvl | input | 1 | 1 = level trigger, 0 = edge trigger |
| ack_req | input | 1 | Processor acknowledge pulse |
| ack_done | output | 1 | One-cycle pulse, acknowledge answered |
| ack_vec | output | 8 | Vector returned by the acknowledge |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address, index in bits 11:4 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| intr | output | 1 | Interrupt line to the processor |
| eoi_bcast | output | 1 | One-cycle end-of-interrupt broadcast |
| eoi_bcast_vec | output | 8 | Vector carried by the broadcast |

## Verification
Read data appears one edge after the read strobe, so the bench samples it at the falling edge that follows. An acknowledge or end-of-interrupt is served two edges after its strobe once the searches are settled. The bench therefore polls `ack_done` and `eoi_bcast` at falling edges within a bounded window instead of assuming one fixed cycle. After each operation the bench idles four cycles, one registered search stage plus one registered line, before it compares `intr` and the priority registers against its arithmetic model. A sweep covers all sixteen task-priority classes, each with a different set of posted vectors.

// File: rtl/iac_pkg.sv
package iac_pkg;
  localparam int ADDR_W = 12;
  localparam int IDX_W  = 8;

  localparam logic [7:0] IX_TPR  = 8'h08;
  localparam logic [7:0] IX_PPR  = 8'h0A;
  localparam logic [7:0] IX_EOI  = 8'h0B;
  localparam logic [7:0] IX_SVR  = 8'h0F;
  localparam logic [7:0] IX_ISR0 = 8'h10;
  localparam logic [7:0] IX_TMR0 = 8'h18;
  localparam logic [7:0] IX_IRR0 = 8'h20;
  localparam logic [7:0] IX_ERR  = 8'h28;

  localparam int SV_EN_BIT   = 8;
  localparam int SV_DIR_BIT  = 12;
  localparam int ERR_BAD_BIT = 7;

  typedef enum logic [3:0] {
    RK_TPR, RK_PPR, RK_EOI, RK_SVR, RK_ISR, RK_TMR, RK_IRR, RK_ERR, RK_BAD
  } rkind_e;

  function automatic rkind_e decode_idx(input logic [7:0] idx, input int nword);
    int i;
    i = int'(idx);
    if (idx == IX_TPR) return RK_TPR;
    if (idx == IX_PPR) return RK_PPR;
    if (idx == IX_EOI) return RK_EOI;
    if (idx == IX_SVR) return RK_SVR;
    if (idx == IX_ERR) return RK_ERR;
    if (i >= int'(IX_ISR0) && i < int'(IX_ISR0) + nword) return RK_ISR;
    if (i >= int'(IX_TMR0) && i < int'(IX_TMR0) + nword) return RK_TMR;
    if (i >= int'(IX_IRR0) && i < int'(IX_IRR0) + nword) return RK_IRR;
    return RK_BAD;
  endfunction
endpackage

// File: rtl/iac_prio_enc.sv
module iac_prio_enc #(
  parameter int W  = 256,
  parameter int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  vec,
  output logic          hit_q,
  output logic [IW-1:0] idx_q
);
  logic          hit_c;
  logic [IW-1:0] idx_c;

  always_comb begin
    hit_c = 1'b0;
    idx_c = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        hit_c = 1'b1;
        idx_c = IW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= 1'b0;
      idx_q <= '0;
    end else begin
      hit_q <= hit_c;
      idx_q <= idx_c;
    end
  end
endmodule

// File: rtl/iac_vec_store.sv
module iac_vec_store #(
  parameter int NVEC = 256,
  parameter int VW   = $clog2(NVEC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_en,
  input  logic [VW-1:0]   set_vec,
  input  logic            set_lvl,
  input  logic            take_en,
  input  logic [VW-1:0]   take_vec,
  input  logic            retire_en,
  input  logic [VW-1:0]   retire_vec,
  output logic [NVEC-1:0] pend,
  output logic [NVEC-1:0] insvc,
  output logic [NVEC-1:0] trig
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= '0;
      insvc <= '0;
      trig  <= '0;
    end else begin
      if (take_en) begin
        pend[take_vec]  <= 1'b0;
        insvc[take_vec] <= 1'b1;
      end
      if (retire_en) insvc[retire_vec] <= 1'b0;
      if (set_en) begin
        pend[set_vec] <= 1'b1;
        trig[set_vec] <= set_lvl;
      end
    end
  end
endmodule

// File: rtl/intr_accept_ctrl.sv
module intr_accept_ctrl
  import iac_pkg::*;
#(
  parameter int NVEC = 256,
  parameter int DW   = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      set_req,
  input  logic [$clog2(NVEC)-1:0]   set_vec,
  input  logic                      set_lvl,
  input  logic                      ack_req,
  output logic                      ack_done,
  output logic [$clog2(NVEC)-1:0]   ack_vec,
  input  logic                      reg_we,
  input  logic                      reg_re,
  input  logic [11:0]               reg_addr,
  input  logic [DW-1:0]             reg_wdata,
  output logic [DW-1:0]             reg_rdata,
  output logic                      intr,
  output logic                      eoi_bcast,
  output logic [$clog2(NVEC)-1:0]   eoi_bcast_vec
);
  localparam int VW     = $clog2(NVEC);
  localparam int NWORD  = NVEC / DW;
  localparam int WSEL   = $clog2(NWORD);
  localparam int CW     = 4;
  localparam int CLS_LO = VW - CW;

  // vector arrays and their registered searches
  logic [NVEC-1:0] pend, insvc, trig;
  logic            pend_hit, isvc_hit;
  logic [VW-1:0]   pend_top, isvc_top;

  // configuration state
  logic [VW-1:0] tpr_q, sv_vec_q;
  logic          sv_en_q, sv_dir_q, err_q;
  logic          ack_pend_q, eoi_pend_q, stale_q;

  // decode
  logic [7:0] idx;
  rkind_e     kind;
  logic       misal, bad_acc;
  assign idx   = reg_addr[11:4];
  assign misal = |reg_addr[3:0];
  assign kind  = misal ? RK_BAD : decode_idx(idx, NWORD);
  assign bad_acc = (reg_we | reg_re) & (kind == RK_BAD);

  // priority arithmetic
  logic [CW-1:0] isvc_cls;
  logic [VW-1:0] ppr;
  logic          deliv;
  assign isvc_cls = isvc_hit ? isvc_top[VW-1:CLS_LO] : '0;
  assign ppr = (tpr_q[VW-1:CLS_LO] >= isvc_cls) ? tpr_q : {isvc_cls, {CLS_LO{1'b0}}};
  assign deliv = pend_hit &&
                 ((ppr == '0) || (pend_top[VW-1:CLS_LO] > ppr[VW-1:CLS_LO]));

  // service scheduling
  logic serve_ack, serve_eoi, take_en, retire_en, eoi_wr, chg;
  assign eoi_wr    = reg_we & (kind == RK_EOI);
  assign serve_ack = ack_pend_q & ~stale_q;
  assign serve_eoi = eoi_pend_q & ~stale_q & ~serve_ack;
  assign take_en   = serve_ack & deliv & sv_en_q;
  assign retire_en = serve_eoi & isvc_hit;
  assign chg       = set_req | take_en | retire_en;

  iac_vec_store #(.NVEC(NVEC), .VW(VW)) u_store (
    .clk(clk), .rst(rst),
    .set_en(set_req), .set_vec(set_vec), .set_lvl(set_lvl),
    .take_en(take_en), .take_vec(pend_top),
    .retire_en(retire_en), .retire_vec(isvc_top),
    .pend(pend), .insvc(insvc), .trig(trig)
  );

  iac_prio_enc #(.W(NVEC), .IW(VW)) u_pend_enc (
    .clk(clk), .rst(rst), .vec(pend), .hit_q(pend_hit), .idx_q(pend_top)
  );

  iac_prio_enc #(.W(NVEC), .IW(VW)) u_isvc_enc (
    .clk(clk), .rst(rst), .vec(insvc), .hit_q(isvc_hit), .idx_q(isvc_top)
  );

  // word views of the arrays for the read port
  logic [DW-1:0] pend_w [NWORD];
  logic [DW-1:0] isvc_w [NWORD];
  logic [DW-1:0] trig_w [NWORD];
  generate
    for (genvar w = 0; w < NWORD; w++) begin : g_words
      assign pend_w[w] = pend[w*DW +: DW];
      assign isvc_w[w] = insvc[w*DW +: DW];
      assign trig_w[w] = trig[w*DW +: DW];
    end
  endgenerate

  logic [WSEL-1:0] wsel;
  logic [DW-1:0]   rd_val;
  assign wsel = idx[WSEL-1:0];

  always_comb begin
    rd_val = '0;
    unique case (kind)
      RK_TPR: rd_val = DW'(tpr_q);
      RK_PPR: rd_val = DW'(ppr);
      RK_SVR: begin
        rd_val[VW-1:0]   = sv_vec_q;
        rd_val[SV_EN_BIT]  = sv_en_q;
        rd_val[SV_DIR_BIT] = sv_dir_q;
      end
      RK_ISR: rd_val = isvc_w[wsel];
      RK_TMR: rd_val = trig_w[wsel];
      RK_IRR: rd_val = pend_w[wsel];
      RK_ERR: rd_val[ERR_BAD_BIT] = err_q;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tpr_q         <= '0;
      sv_vec_q      <= '1;
      sv_en_q       <= 1'b0;
      sv_dir_q      <= 1'b0;
      err_q         <= 1'b0;
      ack_pend_q    <= 1'b0;
      eoi_pend_q    <= 1'b0;
      stale_q       <= 1'b0;
      ack_done      <= 1'b0;
      ack_vec       <= '0;
      eoi_bcast     <= 1'b0;
      eoi_bcast_vec <= '0;
      intr          <= 1'b0;
      reg_rdata     <= '0;
    end else begin
      stale_q    <= chg;
      ack_pend_q <= ack_req | (ack_pend_q & ~serve_ack);
      eoi_pend_q <= eoi_wr | (eoi_pend_q & ~serve_eoi);

      ack_done <= serve_ack;
      if (serve_ack) ack_vec <= take_en ? pend_top : sv_vec_q;

      eoi_bcast <= retire_en & trig[isvc_top] & ~sv_dir_q;
      if (retire_en) eoi_bcast_vec <= isvc_top;

      intr <= (stale_q ? intr : deliv) & sv_en_q;

      if (reg_re) reg_rdata <= rd_val;

      if (reg_we) begin
        unique case (kind)
          RK_TPR: tpr_q <= reg_wdata[VW-1:0];
          RK_SVR: begin
            sv_vec_q <= reg_wdata[VW-1:0];
            sv_en_q  <= reg_wdata[SV_EN_BIT];
            sv_dir_q <= reg_wdata[SV_DIR_BIT];
          end
          RK_ERR: if (reg_wdata == '0) err_q <= 1'b0;
          default: ;
        endcase
      end
      if (bad_acc) err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/iac_checker.sv
module iac_checker #(
  parameter int NVEC = 256,
  parameter int VW   = $clog2(NVEC)
) (
  input logic            clk,
  input logic            rst,
  input logic            intr,
  input logic            sv_en_q,
  input logic            sv_dir_q,
  input logic            ack_done,
  input logic [VW-1:0]   ack_vec,
  input logic            ack_pend_q,
  input logic            take_en,
  input logic [NVEC-1:0] insvc,
  input logic            eoi_bcast
);
  p_intr_gated_r3: assert property (@(posedge clk) disable iff (rst)
    intr |-> $past(sv_en_q));

  p_answer_needs_req_r4: assert property (@(posedge clk) disable iff (rst)
    ack_done |-> $past(ack_pend_q));

  p_taken_in_service_r4: assert property (@(posedge clk) disable iff (rst)
    (ack_done && $past(take_en)) |-> insvc[ack_vec]);

  p_bcast_single_r7: assert property (@(posedge clk) disable iff (rst)
    eoi_bcast |=> !eoi_bcast);

  p_bcast_not_directed_r7: assert property (@(posedge clk) disable iff (rst)
    eoi_bcast |-> !$past(sv_dir_q));
endmodule

bind intr_accept_ctrl iac_checker #(.NVEC(NVEC)) u_iac_checker (
  .clk(clk), .rst(rst), .intr(intr), .sv_en_q(sv_en_q), .sv_dir_q(sv_dir_q),
  .ack_done(ack_done), .ack_vec(ack_vec), .ack_pend_q(ack_pend_q),
  .take_en(take_en), .insvc(insvc), .eoi_bcast(eoi_bcast)
);

// File: tb/test_intr_accept_ctrl.sv
module test_intr_accept_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        set_req = 0, set_lvl = 0, ack_req = 0, reg_we = 0, reg_re = 0;
  logic [7:0]  set_vec = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic        ack_done, intr, eoi_bcast;
  logic [7:0]  ack_vec, eoi_bcast_vec;
  logic [31:0] reg_rdata;

  intr_accept_ctrl i_intr_accept_ctrl (
    .clk(clk), .rst(rst), .set_req(set_req), .set_vec(set_vec), .set_lvl(set_lvl),
    .ack_req(ack_req), .ack_done(ack_done), .ack_vec(ack_vec),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .intr(intr), .eoi_bcast(eoi_bcast),
    .eoi_bcast_vec(eoi_bcast_vec)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // behavioural model
  logic [255:0] m_irr = '0, m_isr = '0, m_tmr = '0;
  int m_tpr = 0, m_sv = 8'hFF;
  bit m_en = 0, m_dir = 0;

  function automatic int top_bit(logic [255:0] a);
    for (int i = 255; i >= 0; i--) if (a[i]) return i;
    return -1;
  endfunction

  function automatic int m_ppr();
    int h, c;
    h = top_bit(m_isr);
    c = (h < 0) ? 0 : (h >> 4);
    return ((m_tpr >> 4) >= c) ? m_tpr : (c << 4);
  endfunction

  function automatic bit m_deliv();
    int h, p;
    h = top_bit(m_irr);
    p = m_ppr();
    return (h >= 0) && (p == 0 || (h >> 4) > (p >> 4));
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] idx, logic [31:0] d, logic [3:0] lo = 4'h0);
    @(negedge clk);
    reg_we = 1; reg_addr = {idx, lo}; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(logic [7:0] idx, output logic [31:0] q, input logic [3:0] lo = 4'h0);
    @(negedge clk);
    reg_re = 1; reg_addr = {idx, lo};
    @(negedge clk);
    reg_re = 0;
    q = reg_rdata;
  endtask

  task automatic setv(int v, bit lvl);
    @(negedge clk);
    set_req = 1; set_vec = v[7:0]; set_lvl = lvl;
    @(negedge clk);
    set_req = 0;
    m_irr[v] = 1'b1;
    m_tmr[v] = lvl;
  endtask

  task automatic settle();
    tick(4);
  endtask

  task automatic do_ack(string req);
    int exp, h;
    bit seen;
    logic [7:0] got;
    @(negedge clk); ack_req = 1;
    @(negedge clk); ack_req = 0;
    seen = 0; got = 0;
    for (int k = 0; k < 8 && !seen; k++) begin
      if (ack_done) begin seen = 1; got = ack_vec; end
      else tick(1);
    end
    if (m_en && m_deliv()) begin
      h = top_bit(m_irr);
      m_irr[h] = 1'b0; m_isr[h] = 1'b1; exp = h;
    end else exp = m_sv;
    chk({req, " ack answered"}, seen, 1);
    chk({req, " ack vector"}, got, exp);
    settle();
  endtask

  task automatic do_eoi(string req);
    int h;
    bit seen, exp_bc;
    logic [7:0] got;
    wr(8'h0B, 32'h0);
    seen = 0; got = 0;
    for (int k = 0; k < 6; k++) begin
      if (eoi_bcast) begin seen = 1; got = eoi_bcast_vec; end
      tick(1);
    end
    h = top_bit(m_isr);
    exp_bc = (h >= 0) && m_tmr[h] && !m_dir;
    if (h >= 0) m_isr[h] = 1'b0;
    chk({req, " broadcast"}, seen, exp_bc);
    if (exp_bc) chk({req, " broadcast vector"}, got, h);
    settle();
  endtask

  task automatic chk_state(string req);
    logic [31:0] q;
    chk({req, " intr"}, intr, m_en && m_deliv());
    rd(8'h0A, q);
    chk({req, " ppr"}, q, m_ppr());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] q;
    int v;
    tick(3);
    rst = 0;
    tick(1);

    // R11 reset state
    chk("R11 intr", intr, 0);
    chk("R11 ack_done", ack_done, 0);
    chk("R11 eoi_bcast", eoi_bcast, 0);
    rd(8'h08, q); chk("R11 tpr", q, 0);
    rd(8'h0F, q); chk("R11 spurious reg", q, 32'hFF);
    rd(8'h28, q); chk("R11 error reg", q, 0);
    rd(8'h21, q); chk("R11 pending word", q, 0);

    // R8 spurious register masking
    wr(8'h0F, 32'hFFFF_FFFF);
    rd(8'h0F, q); chk("R8 kept bits", q, 32'h11FF);
    wr(8'h0F, 32'h0000_00C3);
    m_sv = 8'hC3; m_en = 0; m_dir = 0;
    rd(8'h0F, q); chk("R8 readback", q, 32'hC3);

    // R1 set request and trigger bit
    setv(37, 1);
    settle();
    rd(8'h21, q); chk("R1 pending bit", q, 32'h20);
    rd(8'h19, q); chk("R1 trigger level", q, 32'h20);
    setv(37, 0);
    settle();
    rd(8'h19, q); chk("R1 trigger edge", q, 0);

    // R5 disabled: spurious, arrays kept; R3 line low
    chk("R3 disabled intr", intr, 0);
    do_ack("R5 disabled");
    rd(8'h21, q); chk("R5 pending kept", q, 32'h20);
    rd(8'h11, q); chk("R5 in-service kept", q, 0);

    // R10 read-only registers
    wr(8'h0A, 32'hF0);
    wr(8'h21, 32'h0);
    wr(8'h11, 32'hFFFF_FFFF);
    rd(8'h21, q); chk("R10 pending untouched", q, 32'h20);
    rd(8'h11, q); chk("R10 in-service untouched", q, 0);
    rd(8'h0A, q); chk("R10 ppr untouched", q, 0);

    // R9 illegal access
    rd(8'h05, q); chk("R9 illegal read data", q, 0);
    rd(8'h28, q); chk("R9 error bit", q, 32'h80);
    wr(8'h28, 32'h0);
    rd(8'h28, q); chk("R9 error cleared", q, 0);
    rd(8'h08, q, 4'h4); chk("R9 misaligned read", q, 0);
    rd(8'h28, q); chk("R9 misaligned flags error", q, 32'h80);
    wr(8'h28, 32'h0);

    // enable, drain the first vector
    wr(8'h0F, 32'h1FF);
    m_sv = 8'hFF; m_en = 1;
    settle();
    chk_state("R3 enabled");
    do_ack("R4 first");
    do_eoi("R6 first");
    chk_state("R6 after first");

    // sweep over all task priority classes
    for (int tc = 0; tc < 16; tc++) begin
      m_tpr = (tc << 4) | ((tc * 7) & 15);
      wr(8'h08, m_tpr);
      for (int k = 0; k < 5; k++) begin
        v = (k * 53 + tc * 29 + 7) & 255;
        setv(v, k[0]);
      end
      settle();
      chk_state("R2/R3 after posting");
      for (int n = 0; n < 3; n++) begin
        do_ack("R4/R5 sweep");
        chk_state("R2/R3 after ack");
      end
      do_eoi("R6/R7 sweep");
      chk_state("R2 after eoi");
      m_tpr = 0;
      wr(8'h08, 0);
      settle();
      for (int n = 0; n < 10; n++) begin
        if (top_bit(m_isr) >= 0) do_eoi("R6/R7 drain");
        if (top_bit(m_irr) >= 0) do_ack("R4 drain");
      end
      while (top_bit(m_isr) >= 0) do_eoi("R6 drain tail");
      rd(8'h10 + tc[2:0], q); chk("R6 in-service word empty", q, 0);
      chk_state("R3 drained");
    end

    // R7 directed bit suppresses the broadcast
    wr(8'h0F, 32'h11FF);
    m_dir = 1;
    setv(200, 1);
    settle();
    do_ack("R4 directed");
    do_eoi("R7 directed");
    wr(8'h0F, 32'h1FF);
    m_dir = 0;
    setv(201, 1);
    settle();
    do_ack("R4 level");
    do_eoi("R7 level");
    do_eoi("R6 empty eoi");
    chk_state("R6 final");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule